// File: doc/BRIEF.md
# Disable-Tone Status Hold and Release Controller

This block sits behind a voice-band tone front end and turns its per-interval flags into a stable tone-disable status for each channel. Each channel receives three flags: a 2100 Hz tone is present, a phase reversal was seen, and both monitored bands are quiet. Timing comes from a shared millisecond tick. The flags are only looked at on tick cycles.

A channel sets its status once the tone has lasted long enough. The required time depends on the channel's mode bit. With the bit at 0, the tone must last a long window and contain at least one phase reversal. With the bit at 1, a shorter window is enough and reversals do not matter. After it is set, the status holds with no tone present. It drops only after an unbroken run of quiet ticks. Every set and every clear produces a one-cycle interrupt pulse. If a channel's automatic bit is on, a set status also raises that channel's bypass request, so the host does not have to act.

Top module: `tone_hold_ctrl`

## Requirements
- R1: With the mode bit at 0, the status sets on the tick on which the tone has been present for REV_TICKS consecutive ticks, provided a reversal was flagged on at least one tick of that run. If the reversal comes later in the run, the status sets on the tick of that reversal.
- R2: With the mode bit at 1, the status sets on the tick that completes PLAIN_TICKS consecutive tone ticks, whether or not any reversal is flagged.
- R3: A tick with the tone flag low restarts qualification. It clears both the tone-run count and the memory of a seen reversal.
- R4: Once set, the status stays at 1 while the tone flag is low, for as long as quiet is not met.
- R5: A set status clears on the tick that completes QUIET_TICKS consecutive quiet ticks. Any tick that is not quiet restarts that count.
- R6: The interrupt output is high for exactly one clock, on the clock after each status change. It is low at all other times.
- R7: The bypass request of a channel is 1 exactly when that channel's automatic bit is 1 and its status is 1.
- R8: Reset sets status, interrupt and bypass request to 0 and clears all timers. No interrupt is raised by reset.
- R9: On cycles without a tick, the flags have no effect: the status does not change and no interrupt fires.
- R10: Channels are independent. Stimulus on one channel never changes another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle timing tick; flags are evaluated only when it is high |
| tone_det | input | NCH | Per-channel 2100 Hz tone present flag |
| rev_det | input | NCH | Per-channel phase reversal flag |
| quiet_det | input | NCH | Per-channel both-bands-quiet flag |
| plain_mode | input | NCH | Per-channel mode: 1 = no reversal needed, short window |
| auto_byp | input | NCH | Per-channel automatic bypass enable |
| td_stat | output | NCH | Per-channel latched tone-disable status |
| td_irq | output | NCH | Per-channel one-cycle pulse on status set or clear |
| byp_req | output | NCH | Per-channel automatic bypass request |

## Verification
A qualification count that is off by one moves the set tick one tick early or late. The interrupt pulse moves with it, so the error is visible within one tick of the expected set point. A reversal memory that is not cleared on a tone drop shows up as a set in the reversal mode on a run that never contained a reversal. A release count that is not restarted by a loud tick shows up as an early clear, together with its interrupt, as soon as the quiet ticks add up across the break.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // Tick on which a reversal-mode run qualifies: the later of the window end
  // and the first reversal position (positions count from 1).
  function automatic int unsigned rev_set_tick(input int unsigned window,
                                               input int unsigned first_rev);
    return max2(window, first_rev);
  endfunction

endpackage

// File: rtl/tdc_qual.sv
module tdc_qual
  import tdc_pkg::*;
#(
  parameter int unsigned REV_TICKS   = 1000,
  parameter int unsigned PLAIN_TICKS = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic armed,
  input  logic tone,
  input  logic rev,
  input  logic plain,
  output logic set_evt,
  output logic rev_mem
);
  localparam int unsigned SAT = max2(REV_TICKS, PLAIN_TICKS);
  localparam int unsigned CW  = cnt_width(SAT);
  localparam logic [CW:0] LIM_REV   = (CW+1)'(REV_TICKS);
  localparam logic [CW:0] LIM_PLAIN = (CW+1)'(PLAIN_TICKS);
  localparam logic [CW:0] SAT_V     = (CW+1)'(SAT);

  logic [CW-1:0] run_cnt;
  logic [CW:0]   run_next;
  logic [CW:0]   lim;
  logic          rev_ok;

  assign run_next = {1'b0, run_cnt} + 1'b1;
  assign lim      = plain ? LIM_PLAIN : LIM_REV;
  assign rev_ok   = plain | rev_mem | rev;
  assign set_evt  = tick & armed & tone & (run_next >= lim) & rev_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      rev_mem <= 1'b0;
    end else if (tick) begin
      if (!armed || !tone || set_evt) begin
        run_cnt <= '0;
        rev_mem <= 1'b0;
      end else begin
        if (run_next <= SAT_V) run_cnt <= run_next[CW-1:0];
        rev_mem <= rev_mem | rev;
      end
    end
  end
endmodule

// File: rtl/tdc_release.sv
module tdc_release
  import tdc_pkg::*;
#(
  parameter int unsigned QUIET_TICKS = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic held,
  input  logic quiet,
  output logic clr_evt
);
  localparam int unsigned CW = cnt_width(QUIET_TICKS);
  localparam logic [CW:0] LIM_Q = (CW+1)'(QUIET_TICKS);

  logic [CW-1:0] q_cnt;
  logic [CW:0]   q_next;

  assign q_next  = {1'b0, q_cnt} + 1'b1;
  assign clr_evt = tick & held & quiet & (q_next >= LIM_Q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_cnt <= '0;
    end else if (tick) begin
      if (!held || !quiet || clr_evt) q_cnt <= '0;
      else                            q_cnt <= q_next[CW-1:0];
    end
  end
endmodule

// File: rtl/tdc_chan.sv
module tdc_chan #(
  parameter int unsigned REV_TICKS   = 1000,
  parameter int unsigned PLAIN_TICKS = 400,
  parameter int unsigned QUIET_TICKS = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tone,
  input  logic rev,
  input  logic quiet,
  input  logic plain,
  input  logic auto_en,
  output logic td,
  output logic irq,
  output logic byp,
  output logic rev_mem
);
  logic set_evt;
  logic clr_evt;

  tdc_qual #(.REV_TICKS(REV_TICKS), .PLAIN_TICKS(PLAIN_TICKS)) u_qual (
    .clk(clk), .rst_n(rst_n), .tick(tick), .armed(~td), .tone(tone),
    .rev(rev), .plain(plain), .set_evt(set_evt), .rev_mem(rev_mem)
  );

  tdc_release #(.QUIET_TICKS(QUIET_TICKS)) u_rel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .held(td), .quiet(quiet),
    .clr_evt(clr_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      td  <= 1'b0;
      irq <= 1'b0;
    end else begin
      irq <= set_evt | clr_evt;
      if (set_evt)      td <= 1'b1;
      else if (clr_evt) td <= 1'b0;
    end
  end

  assign byp = auto_en & td;
endmodule

// File: rtl/tone_hold_ctrl.sv
module tone_hold_ctrl #(
  parameter int unsigned NCH         = 4,
  parameter int unsigned REV_TICKS   = 1000,
  parameter int unsigned PLAIN_TICKS = 400,
  parameter int unsigned QUIET_TICKS = 400
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ms_tick,
  input  logic [NCH-1:0] tone_det,
  input  logic [NCH-1:0] rev_det,
  input  logic [NCH-1:0] quiet_det,
  input  logic [NCH-1:0] plain_mode,
  input  logic [NCH-1:0] auto_byp,
  output logic [NCH-1:0] td_stat,
  output logic [NCH-1:0] td_irq,
  output logic [NCH-1:0] byp_req
);
  logic [NCH-1:0] rev_mem_w;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tdc_chan #(
      .REV_TICKS(REV_TICKS), .PLAIN_TICKS(PLAIN_TICKS), .QUIET_TICKS(QUIET_TICKS)
    ) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick),
      .tone(tone_det[c]), .rev(rev_det[c]), .quiet(quiet_det[c]),
      .plain(plain_mode[c]), .auto_en(auto_byp[c]),
      .td(td_stat[c]), .irq(td_irq[c]), .byp(byp_req[c]), .rev_mem(rev_mem_w[c])
    );
  end
endmodule

// File: rtl/tdc_chk.sv
module tdc_chk #(
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic [NCH-1:0] tone,
  input logic [NCH-1:0] rev,
  input logic [NCH-1:0] quiet,
  input logic [NCH-1:0] plain,
  input logic [NCH-1:0] td,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] rev_mem
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    p_irq_marks_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] == (td[i] != $past(td[i])));

    p_hold_without_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> $stable(td[i]));

    p_set_needs_tone_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(td[i]) |-> $past(tone[i]));

    p_set_needs_reversal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(td[i]) && !$past(plain[i])) |-> ($past(rev_mem[i]) || $past(rev[i])));

    p_clear_needs_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(td[i]) |-> $past(quiet[i]));
  end
endmodule

bind tone_hold_ctrl tdc_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(ms_tick), .tone(tone_det), .rev(rev_det),
  .quiet(quiet_det), .plain(plain_mode), .td(td_stat), .irq(td_irq),
  .rev_mem(rev_mem_w)
);

// File: tb/tb_tone_hold_ctrl.sv
module tb_tone_hold_ctrl;
  localparam int CLK_P   = 10;
  localparam int NCH     = 2;
  localparam int REV_T   = 6;
  localparam int PLAIN_T = 3;
  localparam int QUIET_T = 3;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic           rst_n;
  logic           ms_tick;
  logic [NCH-1:0] tone_det, rev_det, quiet_det, plain_mode, auto_byp;
  logic [NCH-1:0] td_stat, td_irq, byp_req;
  logic           c1_tone, c1_rev, c1_quiet;
  logic [NCH-1:0] prev_td;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  tone_hold_ctrl #(
    .NCH(NCH), .REV_TICKS(REV_T), .PLAIN_TICKS(PLAIN_T), .QUIET_TICKS(QUIET_T)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .tone_det(tone_det),
    .rev_det(rev_det), .quiet_det(quiet_det), .plain_mode(plain_mode),
    .auto_byp(auto_byp), .td_stat(td_stat), .td_irq(td_irq), .byp_req(byp_req)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ms_tick = 1'b0;
    tone_det = '0; rev_det = '0; quiet_det = '0; plain_mode = '0; auto_byp = '0;
    c1_tone = 1'b0; c1_rev = 1'b0; c1_quiet = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    prev_td = td_stat;
  endtask

  // One tick with channel 0 flags t/r/q and channel 1 flags from c1_*.
  // A quiet cycle with all flags high and no tick precedes it (R9).
  task automatic step(input logic t, input logic r, input logic q);
    @(negedge clk);
    chk("R9", "td held on no-tick cycle ch0", int'(td_stat[0]), int'(prev_td[0]));
    chk("R9", "td held on no-tick cycle ch1", int'(td_stat[1]), int'(prev_td[1]));
    chk("R6", "irq low on no-tick cycle", int'(td_irq), 0);
    tone_det = {c1_tone, t}; rev_det = {c1_rev, r}; quiet_det = {c1_quiet, q};
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
    tone_det = '1; rev_det = '1; quiet_det = '1;
    prev_td = td_stat;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int set_t;
    do_reset();
    // R8: reset state
    chk("R8", "td after reset", int'(td_stat), 0);
    chk("R8", "irq after reset", int'(td_irq), 0);
    chk("R8", "byp after reset", int'(byp_req), 0);

    // R1 / R2 sweep: run length L, single reversal at position p (0 = none)
    for (int mode = 0; mode < 2; mode++) begin
      for (int L = 1; L <= 8; L++) begin
        for (int p = 0; p <= L; p++) begin
          do_reset();
          plain_mode[0] = mode[0];
          if (mode == 1) set_t = PLAIN_T;
          else if (p == 0) set_t = 999;
          else set_t = (p > REV_T) ? p : REV_T;
          for (int k = 1; k <= L; k++) begin
            step(1'b1, k == p, 1'b0);
            chk(mode ? "R2" : "R1", "td during run", int'(td_stat[0]), int'(k >= set_t));
            chk("R6", "irq at set", int'(td_irq[0]), int'(k == set_t));
            chk("R10", "idle ch1 td", int'(td_stat[1]), 0);
          end
          step(1'b0, 1'b0, 1'b0);
          chk("R4", "td after tone drop", int'(td_stat[0]), int'(L >= set_t));
        end
      end
    end

    // R3: tone drop restarts the count (plain mode)
    do_reset();
    plain_mode[0] = 1'b1;
    step(1, 0, 0); step(1, 0, 0); step(0, 0, 0); step(1, 0, 0); step(1, 0, 0);
    chk("R3", "no set across a drop", int'(td_stat[0]), 0);
    step(1, 0, 0);
    chk("R3", "set after fresh full run", int'(td_stat[0]), 1);

    // R3: tone drop forgets the reversal (reversal mode)
    do_reset();
    step(1, 1, 0);
    for (int k = 0; k < 4; k++) step(1, 0, 0);
    step(0, 0, 0);
    for (int k = 0; k < REV_T + 2; k++) step(1, 0, 0);
    chk("R3", "reversal memory cleared by drop", int'(td_stat[0]), 0);
    step(1, 1, 0);
    chk("R3", "set on reversal after long run", int'(td_stat[0]), 1);
    chk("R6", "irq on that set", int'(td_irq[0]), 1);

    // R4: hold with no tone and no quiet
    for (int k = 0; k < 10; k++) step(0, 0, 0);
    chk("R4", "held for many silent-but-loud ticks", int'(td_stat[0]), 1);

    // R5 sweep: q quiet ticks then one loud tick
    for (int q = 1; q <= QUIET_T + 2; q++) begin
      do_reset();
      plain_mode[0] = 1'b1;
      for (int k = 0; k < PLAIN_T; k++) step(1, 0, 0);
      for (int k = 1; k <= q; k++) begin
        step(0, 0, 1);
        chk("R5", "td during quiet run", int'(td_stat[0]), int'(k < QUIET_T));
        chk("R6", "irq at clear", int'(td_irq[0]), int'(k == QUIET_T));
      end
      step(0, 0, 0);
      chk("R5", "td after loud tick", int'(td_stat[0]), int'(q < QUIET_T));
    end

    // R5: loud tick restarts release count
    do_reset();
    plain_mode[0] = 1'b1;
    for (int k = 0; k < PLAIN_T; k++) step(1, 0, 0);
    for (int k = 0; k < QUIET_T - 1; k++) step(0, 0, 1);
    step(0, 0, 0);
    for (int k = 0; k < QUIET_T - 1; k++) step(0, 0, 1);
    chk("R5", "no clear across loud tick", int'(td_stat[0]), 1);
    step(0, 0, 1);
    chk("R5", "clear after full quiet run", int'(td_stat[0]), 0);

    // R7: automatic bypass request
    do_reset();
    plain_mode = '1; auto_byp = 2'b01;
    c1_tone = 1'b1;
    for (int k = 0; k < PLAIN_T; k++) step(1, 0, 0);
    chk("R7", "byp ch0 auto with td", int'(byp_req[0]), 1);
    chk("R7", "byp ch1 no auto with td", int'(byp_req[1]), 0);
    chk("R10", "ch1 set by its own run", int'(td_stat[1]), 1);
    c1_tone = 1'b0; c1_quiet = 1'b1;
    for (int k = 0; k < QUIET_T; k++) step(0, 0, 0);
    chk("R10", "ch1 cleared, ch0 still held", int'(td_stat), 1);
    chk("R7", "byp ch0 still requested", int'(byp_req[0]), 1);
    c1_quiet = 1'b0;
    for (int k = 0; k < QUIET_T; k++) step(0, 0, 1);
    chk("R7", "byp drops with td", int'(byp_req[0]), 0);
    auto_byp = 2'b00;
    for (int k = 0; k < PLAIN_T; k++) step(1, 0, 0);
    @(negedge clk);
    chk("R7", "no byp without auto", int'(byp_req[0]), 0);
    chk("R7", "td set without auto", int'(td_stat[0]), 1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule